// File: doc/BRIEF.md
# Calibrated Thermal Code Converter

This block turns a 10-bit reading from an on-die temperature sensor into a signed temperature in millidegrees Celsius. It also runs the reverse mapping, so that alarm threshold codes can be produced from target temperatures. The two directions share one linear model: temperature equals a calibrated slope times the code, minus a calibrated intercept. The nominal slope of 262 is scaled by a per-mille ratio. The nominal intercept of 66400 is shifted by 250 for each unit of trim that a delta value sits away from its centre of 128.

Calibration comes from fuse-derived inputs and is captured on a one-cycle load strobe. A request is accepted on a start pulse when the unit is idle. The unit then derives the slope with a bit-serial restoring divider and, for the reverse direction, divides a second time. The result is announced by a one-cycle done pulse.

Top module: `tcc_conv`

## Requirements
- R1: When mode is 0 (forward), the result on `temp_out` equals k_cal * code - b_cal as a 32-bit signed value, where code is the clamped `code_in`.
- R2: A forward `code_in` above 1000 is treated as 1000.
- R3: The ratio is 1000 - `cal_ratio_off` when `cal_sign` is 1, and 1000 + `cal_ratio_off` when it is 0. k_cal = floor(262 * ratio / 1000).
- R4: b_cal = 66400 + (`cal_delta` - 128) * 250, with `cal_delta` unsigned.
- R5: When mode is 1 (inverse), `temp_in` (signed) is first limited to the range -40000 to 120000.
- R6: The inverse result on `code_out` is floor((t + b_cal) / k_cal), capped at 999. A negative numerator gives 0. The 120000 and 75000 threshold targets follow the same path.
- R7: Before any load, the unit behaves as if it were loaded with sign 0, offset 0 and delta 128 (k_cal 262, b_cal 66400).
- R8: `done` is high for exactly one cycle per accepted request. `busy` is high from the cycle after acceptance until `done` rises, and is low while `done` is high.
- R9: A start pulse seen while `busy` is high is dropped. It neither alters the running result nor causes a later `done`.
- R10: After reset, `busy`, `done`, `temp_out` and `code_out` are all 0.
- R11: Calibration is sampled when a request is accepted. A load made while a request runs applies only from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_load | input | 1 | Capture the calibration inputs this cycle |
| cal_sign | input | 1 | 1 subtracts the ratio offset, 0 adds it |
| cal_ratio_off | input | 9 | Per-mille slope trim |
| cal_delta | input | 8 | Intercept trim, centred on 128 |
| start | input | 1 | Request a conversion (taken only when idle) |
| mode | input | 1 | 0 = code to temperature, 1 = temperature to code |
| code_in | input | 10 | Sensor code for the forward direction |
| temp_in | input | 32 | Signed millidegree temperature for the inverse direction |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result-valid pulse |
| temp_out | output | 32 | Forward result, signed millidegrees |
| code_out | output | 10 | Inverse result code |

## Verification
The forward direction is swept over every code from 0 to 1023 at the default calibration, and at a stride of three under three trimmed calibrations. Codes above 1000 separate correct input clamping from a raw product, and the differing trims expose mistakes in the sign of the ratio or the intercept step. The inverse direction is swept from -45000 to 125000 in 500 steps. This covers the lower clamp together with a negative numerator, the upper clamp and the 999 cap. The two threshold targets are checked as well. Directed sequences check that a start given while busy is dropped and that a load made during a request does not affect the running result.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam int NOM_SLOPE    = 262;
   localparam int NOM_ICPT     = 66400;
   localparam int RATIO_UNIT   = 1000;
   localparam int DELTA_MID    = 128;
   localparam int DELTA_STEP   = 250;
   localparam int TEMP_MIN     = -40000;
   localparam int TEMP_MAX     = 120000;
   localparam int CODE_IN_MAX  = 1000;
   localparam int CODE_OUT_MAX = 999;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOPE,
      ST_EVAL,
      ST_QUOT
   } conv_state_t;
endpackage

// File: rtl/tcc_divider.sv
module tcc_divider #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         fin,
   output logic [W-1:0] quot
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     rem_q;
   logic [W-1:0]     q_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [W:0]       shifted;
   logic [W:0]       diff;

   always_comb begin
      shifted = {rem_q, q_q[W-1]};
      diff    = shifted - {1'b0, divisor};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem_q <= '0;
            q_q   <= dividend;
            cnt_q <= CNT_W'(W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (!diff[W]) begin
               rem_q <= diff[W-1:0];
               q_q   <= {q_q[W-2:0], 1'b1};
            end else begin
               rem_q <= shifted[W-1:0];
               q_q   <= {q_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end

   assign quot = q_q;
endmodule

// File: rtl/tcc_cal.sv
module tcc_cal #(
   parameter int OFF_W   = 9,
   parameter int DELTA_W = 8,
   parameter int RATIO_W = 11,
   parameter int TEMP_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     sign_in,
   input  logic [OFF_W-1:0]         off_in,
   input  logic [DELTA_W-1:0]       delta_in,
   output logic [RATIO_W-1:0]       ratio,
   output logic signed [TEMP_W-1:0] icpt
);
   import tcc_pkg::*;

   logic               sign_q;
   logic [OFF_W-1:0]   off_q;
   logic [DELTA_W-1:0] delta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sign_q  <= 1'b0;
         off_q   <= '0;
         delta_q <= DELTA_W'(DELTA_MID);
      end else if (load) begin
         sign_q  <= sign_in;
         off_q   <= off_in;
         delta_q <= delta_in;
      end
   end

   always_comb begin
      if (sign_q) ratio = RATIO_W'(RATIO_UNIT) - RATIO_W'(off_q);
      else        ratio = RATIO_W'(RATIO_UNIT) + RATIO_W'(off_q);
      icpt = TEMP_W'(NOM_ICPT + (int'(delta_q) - DELTA_MID) * DELTA_STEP);
   end
endmodule

// File: rtl/tcc_conv.sv
module tcc_conv #(
   parameter int CODE_W  = 10,
   parameter int TEMP_W  = 32,
   parameter int OFF_W   = 9,
   parameter int DELTA_W = 8,
   parameter int DIV_W   = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal_load,
   input  logic                     cal_sign,
   input  logic [OFF_W-1:0]         cal_ratio_off,
   input  logic [DELTA_W-1:0]       cal_delta,
   input  logic                     start,
   input  logic                     mode,
   input  logic [CODE_W-1:0]        code_in,
   input  logic signed [TEMP_W-1:0] temp_in,
   output logic                     busy,
   output logic                     done,
   output logic signed [TEMP_W-1:0] temp_out,
   output logic [CODE_W-1:0]        code_out
);
   import tcc_pkg::*;

   localparam int RATIO_W = $clog2(RATIO_UNIT + (1 << OFF_W));

   initial begin
      assert ((1 << DIV_W) > NOM_SLOPE * (RATIO_UNIT + (1 << OFF_W)))
         else $error("DIV_W too narrow for slope product");
      assert ((1 << CODE_W) > CODE_IN_MAX)
         else $error("CODE_W too narrow");
      assert (RATIO_UNIT > (1 << OFF_W))
         else $error("OFF_W allows a non-positive ratio");
   end

   logic [RATIO_W-1:0]       ratio_w;
   logic signed [TEMP_W-1:0] icpt_w;
   conv_state_t              st_q;
   logic                     mode_q;
   logic [CODE_W-1:0]        code_q;
   logic signed [TEMP_W-1:0] temp_q;
   logic signed [TEMP_W-1:0] icpt_q;
   logic [DIV_W-1:0]         slope_q;
   logic                     div_go;
   logic [DIV_W-1:0]         div_a;
   logic [DIV_W-1:0]         div_b;
   logic                     div_fin;
   logic [DIV_W-1:0]         div_q;
   logic [CODE_W-1:0]        code_clamp;
   logic signed [TEMP_W-1:0] temp_clamp;
   logic signed [TEMP_W-1:0] numer;
   logic signed [TEMP_W-1:0] fwd_val;

   tcc_cal #(
      .OFF_W(OFF_W), .DELTA_W(DELTA_W), .RATIO_W(RATIO_W), .TEMP_W(TEMP_W)
   ) u_cal (
      .clk(clk), .rst_n(rst_n), .load(cal_load), .sign_in(cal_sign),
      .off_in(cal_ratio_off), .delta_in(cal_delta),
      .ratio(ratio_w), .icpt(icpt_w)
   );

   tcc_divider #(.W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_a),
      .divisor(div_b), .fin(div_fin), .quot(div_q)
   );

   always_comb begin
      code_clamp = (code_in > CODE_W'(CODE_IN_MAX)) ? CODE_W'(CODE_IN_MAX) : code_in;
      if (temp_in < TEMP_W'(TEMP_MIN))      temp_clamp = TEMP_W'(TEMP_MIN);
      else if (temp_in > TEMP_W'(TEMP_MAX)) temp_clamp = TEMP_W'(TEMP_MAX);
      else                                  temp_clamp = temp_in;
      numer   = temp_q + icpt_q;
      fwd_val = $signed(TEMP_W'(slope_q)) * $signed(TEMP_W'(code_q)) - icpt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mode_q   <= 1'b0;
         code_q   <= '0;
         temp_q   <= '0;
         icpt_q   <= '0;
         slope_q  <= '0;
         div_go   <= 1'b0;
         div_a    <= '0;
         div_b    <= '0;
         done     <= 1'b0;
         temp_out <= '0;
         code_out <= '0;
      end else begin
         div_go <= 1'b0;
         done   <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start) begin
               mode_q <= mode;
               code_q <= code_clamp;
               temp_q <= temp_clamp;
               icpt_q <= icpt_w;
               div_a  <= DIV_W'(NOM_SLOPE * int'(ratio_w));
               div_b  <= DIV_W'(RATIO_UNIT);
               div_go <= 1'b1;
               st_q   <= ST_SLOPE;
            end
            ST_SLOPE: if (div_fin) begin
               slope_q <= div_q;
               st_q    <= ST_EVAL;
            end
            ST_EVAL: begin
               if (!mode_q) begin
                  temp_out <= fwd_val;
                  done     <= 1'b1;
                  st_q     <= ST_IDLE;
               end else if (numer[TEMP_W-1]) begin
                  code_out <= '0;
                  done     <= 1'b1;
                  st_q     <= ST_IDLE;
               end else begin
                  div_a  <= DIV_W'(numer);
                  div_b  <= slope_q;
                  div_go <= 1'b1;
                  st_q   <= ST_QUOT;
               end
            end
            ST_QUOT: if (div_fin) begin
               code_out <= (div_q > DIV_W'(CODE_OUT_MAX)) ? CODE_W'(CODE_OUT_MAX)
                                                          : div_q[CODE_W-1:0];
               done     <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/tcc_conv_chk.sv
module tcc_conv_chk #(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [CODE_W-1:0] code_out
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   code_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (code_out <= CODE_W'(999)));

   // R9
   start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

bind tcc_conv tcc_conv_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .done(done), .code_out(code_out)
);

// File: tb/tcc_conv_bench.sv
`timescale 1ns/1ps
module tcc_conv_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cal_load = 1'b0;
   logic        cal_sign = 1'b0;
   logic [8:0]  cal_ratio_off = '0;
   logic [7:0]  cal_delta = 8'd128;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [9:0]  code_in = '0;
   logic signed [31:0] temp_in = '0;
   logic        busy;
   logic        done;
   logic signed [31:0] temp_out;
   logic [9:0]  code_out;

   int n_vec = 0;
   int n_bad = 0;
   int r_sign = 0, r_off = 0, r_delta = 128;

   always #2 clk = ~clk;

   tcc_conv u_tcc_conv (
      .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_sign(cal_sign),
      .cal_ratio_off(cal_ratio_off), .cal_delta(cal_delta), .start(start),
      .mode(mode), .code_in(code_in), .temp_in(temp_in), .busy(busy),
      .done(done), .temp_out(temp_out), .code_out(code_out)
   );

   function automatic int ref_k(int s, int o);
      int ratio = (s != 0) ? 1000 - o : 1000 + o;
      return (262 * ratio) / 1000;
   endfunction

   function automatic int ref_b(int d);
      return 66400 + (d - 128) * 250;
   endfunction

   function automatic int ref_fwd(int s, int o, int d, int c);
      int cc = (c > 1000) ? 1000 : c;
      return ref_k(s, o) * cc - ref_b(d);
   endfunction

   function automatic int ref_inv(int s, int o, int d, int t);
      int tc = (t < -40000) ? -40000 : ((t > 120000) ? 120000 : t);
      int n  = tc + ref_b(d);
      int q;
      if (n < 0) return 0;
      q = n / ref_k(s, o);
      return (q > 999) ? 999 : q;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_cal(int s, int o, int d);
      @(negedge clk);
      cal_load = 1'b1; cal_sign = s[0]; cal_ratio_off = o[8:0]; cal_delta = d[7:0];
      @(negedge clk);
      cal_load = 1'b0;
      r_sign = s; r_off = o; r_delta = d;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic convert(bit m, int c, int t);
      @(negedge clk);
      start = 1'b1; mode = m; code_in = c[9:0]; temp_in = t;
      @(negedge clk);
      start = 1'b0;
      wait_done();
   endtask

   task automatic post_done(string req);
      check(done && !busy, req, {30'd0, done, busy}, 2);
      @(negedge clk);
      check(!done, "R8 done single cycle", int'(done), 0);
   endtask

   task automatic sweep_fwd(int step, string tag);
      for (int c = 0; c < 1024; c += step) begin
         convert(1'b0, c, 0);
         check(temp_out == ref_fwd(r_sign, r_off, r_delta, c), tag,
               temp_out, ref_fwd(r_sign, r_off, r_delta, c));
         if (c % 97 == 0) post_done("R8 done with busy low");
      end
   endtask

   task automatic sweep_inv(string tag);
      for (int t = -45000; t <= 125000; t += 500) begin
         convert(1'b1, 0, t);
         check(int'(code_out) == ref_inv(r_sign, r_off, r_delta, t), tag,
               int'(code_out), ref_inv(r_sign, r_off, r_delta, t));
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      int cnt;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!busy && !done, "R10 flags after reset", {30'd0, busy, done}, 0);
      check(temp_out == 0, "R10 temp_out after reset", temp_out, 0);
      check(code_out == 0, "R10 code_out after reset", int'(code_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 defaults, R1 forward, R2 clamp above 1000
      sweep_fwd(1, "R1 R2 R7 forward default");
      // R6 thresholds with defaults (R7)
      convert(1'b1, 0, 120000);
      check(int'(code_out) == ref_inv(0, 0, 128, 120000), "R6 overheat threshold",
            int'(code_out), ref_inv(0, 0, 128, 120000));
      convert(1'b1, 0, 75000);
      check(int'(code_out) == ref_inv(0, 0, 128, 75000), "R6 hot threshold",
            int'(code_out), ref_inv(0, 0, 128, 75000));
      // R5 R6 inverse sweep
      sweep_inv("R5 R6 R7 inverse default");

      // R3 R4 trimmed calibrations
      load_cal(1, 300, 40);
      sweep_fwd(3, "R1 R3 R4 forward sign1");
      sweep_inv("R3 R4 R5 R6 inverse sign1");
      load_cal(0, 511, 255);
      sweep_fwd(3, "R1 R3 R4 forward sign0 max");
      sweep_inv("R3 R4 R5 R6 inverse sign0 max");
      load_cal(1, 511, 0);
      sweep_fwd(3, "R1 R3 R4 forward sign1 max");
      sweep_inv("R3 R4 R5 R6 inverse negative numerator");

      // R9 start while busy is dropped
      load_cal(0, 0, 128);
      @(negedge clk);
      start = 1'b1; mode = 1'b0; code_in = 10'd500;
      @(negedge clk);
      code_in = 10'd10; mode = 1'b1; temp_in = 0;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check(temp_out == ref_fwd(0, 0, 128, 500), "R9 busy start ignored",
            temp_out, ref_fwd(0, 0, 128, 500));
      cnt = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         if (done) cnt++;
      end
      check(cnt == 0, "R9 no extra done", cnt, 0);

      // R11 load during a request applies next time
      @(negedge clk);
      start = 1'b1; mode = 1'b0; code_in = 10'd700;
      @(negedge clk);
      start = 1'b0;
      cal_load = 1'b1; cal_sign = 1'b1; cal_ratio_off = 9'd200; cal_delta = 8'd10;
      @(negedge clk);
      cal_load = 1'b0;
      r_sign = 1; r_off = 200; r_delta = 10;
      wait_done();
      check(temp_out == ref_fwd(0, 0, 128, 700), "R11 running request keeps cal",
            temp_out, ref_fwd(0, 0, 128, 700));
      convert(1'b0, 700, 0);
      check(temp_out == ref_fwd(1, 200, 10, 700), "R11 next request uses new cal",
            temp_out, ref_fwd(1, 200, 10, 700));

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule